// File: doc/BRIEF.md
# PLL Configuration and Core Clock Select Controller

This block is the digital control side of a clock-multiplying PLL. Software writes two registers over a simple write port. The configuration register holds the multiplier and the output divider code. The control register holds the enable and connect bits. The block drives the enable, multiplier and divider to an abstract PLL and takes back a lock indication. It produces the core clock select (bypass oscillator or PLL output) and a packed status word.

Bringing the PLL into use takes three steps in order. First the PLL is enabled. Then the block waits for lock. Only then may the PLL be connected as the core clock source. A connect request that arrives too early is dropped. Losing lock while connected returns the core clock to the oscillator path in the same cycle and sets a sticky flag. The multiplier and divider can change only while the PLL is off, so the loop never sees its ratio move under it. The lock input is taken to be already synchronous to `clk`. Clock multiplexing circuitry, the analog loop and the oscillator are not part of the block.

Top module: `pll_clkctl`

## Requirements
- R1: After reset, enable, connect, lost flag, select and the status word are all 0, the multiplier code is 0 (multiply by 1) and the divider code is 0 (divide by 2).
- R2: A write with `wr_addr`=1 while the PLL is disabled loads the multiplier code from `wr_data[4:0]` (code c means multiply by c+1, so 1 to 32) and the divider code from `wr_data[6:5]` (code k means divide by 2<<k, so 2, 4, 8 or 16). The new values appear on `pll_mult_o` and `pll_div_o` one cycle later.
- R3: A write with `wr_addr`=1 while the PLL is enabled is ignored, and the multiplier and divider outputs keep their values.
- R4: A write with `wr_addr`=0 sets enable from `wr_data[0]`. Writing enable 0 also clears connect.
- R5: A connect request (`wr_addr`=0 with `wr_data[1]`=1 and `wr_data[0]`=1) is accepted only if enable was already 1 and `pll_lock` is high in the write cycle. Otherwise it is ignored and `clk_sel_o` stays 0.
- R6: `clk_sel_o` is 1 only while connect is 1 and `pll_lock` is high. It drops in the same cycle that `pll_lock` falls.
- R7: If `pll_lock` is low while connected, then from the next cycle connect is 0 and the lost flag is 1. Connect stays 0 when lock returns. The lost flag clears only on reset or on an accepted connect.
- R8: `status_o` holds enable in bit 0, connect in bit 1, `pll_lock` delayed one cycle in bit 2, divider code in bits [4:3], multiplier code in bits [9:5] and the lost flag in bit 10.
- R9: A control write with enable 1 and connect 0 disconnects the PLL and leaves it enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects configuration |
| wr_data | input | 7 | Write data |
| pll_lock | input | 1 | Lock indication from the PLL, synchronous |
| pll_en_o | output | 1 | PLL enable |
| pll_mult_o | output | 5 | Active multiplier code (value minus one) |
| pll_div_o | output | 2 | Active output divider code |
| clk_sel_o | output | 1 | Core clock select, 1 selects the PLL output |
| status_o | output | 11 | Packed status word |

## Verification
If the enable or connect state is wrong, it shows on `clk_sel_o` and `status_o` in the cycle after the offending write. The worst case is a connect that should have been refused, which sends an unlocked PLL clock to the core. A missing freeze of the configuration shows as a changed `pll_mult_o` or `pll_div_o` one cycle after a write made while the PLL was enabled. A slow fallback on lock loss shows as `clk_sel_o` staying high for part of a cycle after `pll_lock` falls. The bench therefore samples the select within that same cycle.

// File: rtl/pll_clkctl_pkg.sv
`timescale 1ns/1ps
package pll_clkctl_pkg;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_CONN_BIT = 1;

  typedef struct packed {
    logic lost;
    logic conn;
    logic en;
  } link_st_t;
endpackage

// File: rtl/pll_cfg_hold.sv
`timescale 1ns/1ps
module pll_cfg_hold #(
  parameter int MULT_W = 5,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              freeze,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [DIV_W-1:0]  div_in,
  output logic [MULT_W-1:0] mult_q,
  output logic [DIV_W-1:0]  div_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= '0;
      div_q  <= '0;
    end else if (load && !freeze) begin
      mult_q <= mult_in;
      div_q  <= div_in;
    end
  end
endmodule

// File: rtl/pll_link_ctl.sv
`timescale 1ns/1ps
module pll_link_ctl
  import pll_clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic en_req,
  input  logic conn_req,
  input  logic lock_in,
  output logic en_q,
  output logic conn_q,
  output logic lost_q,
  output logic lock_q,
  output logic sel
);
  link_st_t cur, nxt;

  assign cur = '{lost: lost_q, conn: conn_q, en: en_q};

  always_comb begin
    nxt = cur;
    if (ctl_wr) begin
      nxt.en = en_req;
      if (!en_req || !conn_req) begin
        nxt.conn = 1'b0;
      end else if (cur.en && lock_in) begin
        nxt.conn = 1'b1;
        nxt.lost = 1'b0;
      end
    end
    // Lock loss while connected wins over any write in the same cycle.
    if (cur.conn && !lock_in) begin
      nxt.conn = 1'b0;
      nxt.lost = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      conn_q <= 1'b0;
      lost_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      en_q   <= nxt.en;
      conn_q <= nxt.conn;
      lost_q <= nxt.lost;
      lock_q <= lock_in;
    end
  end

  // Combinational gate with lock so fallback needs no clock edge.
  assign sel = conn_q && lock_in;
endmodule

// File: rtl/pll_clkctl.sv
`timescale 1ns/1ps
module pll_clkctl
  import pll_clkctl_pkg::*;
#(
  parameter  int MULT_W = 5,
  parameter  int DIV_W  = 2,
  localparam int DATA_W = MULT_W + DIV_W,
  localparam int STAT_W = MULT_W + DIV_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pll_lock,
  output logic              pll_en_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic              clk_sel_o,
  output logic [STAT_W-1:0] status_o
);
  logic cfg_load, ctl_wr;
  logic conn_q, lost_q, lock_q;
  logic unused_ctl_bits;

  assign cfg_load        = wr_en && wr_addr;
  assign ctl_wr          = wr_en && !wr_addr;
  assign unused_ctl_bits = ^wr_data[DATA_W-1:2];

  pll_cfg_hold #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (cfg_load),
    .freeze  (pll_en_o),
    .mult_in (wr_data[MULT_W-1:0]),
    .div_in  (wr_data[DATA_W-1:MULT_W]),
    .mult_q  (pll_mult_o),
    .div_q   (pll_div_o)
  );

  pll_link_ctl u_link (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .en_req   (wr_data[CTL_EN_BIT]),
    .conn_req (wr_data[CTL_CONN_BIT]),
    .lock_in  (pll_lock),
    .en_q     (pll_en_o),
    .conn_q   (conn_q),
    .lost_q   (lost_q),
    .lock_q   (lock_q),
    .sel      (clk_sel_o)
  );

  assign status_o = {lost_q, pll_mult_o, pll_div_o, lock_q, conn_q, pll_en_o};
endmodule

// File: rtl/pll_clkctl_chk.sv
`timescale 1ns/1ps
module pll_clkctl_chk #(
  parameter int MULT_W = 5,
  parameter int DIV_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pll_lock,
  input logic              pll_en_o,
  input logic [MULT_W-1:0] pll_mult_o,
  input logic [DIV_W-1:0]  pll_div_o,
  input logic              clk_sel_o,
  input logic              conn_st,
  input logic              lost_st
);
  // R6: the PLL path is selected only while it is enabled and locked
  assert_sel_locked_R6: assert property (@(posedge clk) disable iff (rst)
    clk_sel_o |-> (pll_lock && pll_en_o));

  // R3: an enabled PLL keeps its ratio through the next edge
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    pll_en_o |=> ($stable(pll_mult_o) && $stable(pll_div_o)));

  // R5: no connection can form while the PLL is disabled
  assert_conn_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    !pll_en_o |=> !conn_st);

  // R7: lock loss while connected drops connect and raises the flag
  assert_loss_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (conn_st && !pll_lock) |=> (lost_st && !conn_st));
endmodule

bind pll_clkctl pll_clkctl_chk #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pll_lock   (pll_lock),
  .pll_en_o   (pll_en_o),
  .pll_mult_o (pll_mult_o),
  .pll_div_o  (pll_div_o),
  .clk_sel_o  (clk_sel_o),
  .conn_st    (status_o[1]),
  .lost_st    (status_o[MULT_W+DIV_W+3])
);

// File: tb/pll_clkctl_tb.sv
`timescale 1ns/1ps
module pll_clkctl_tb;
  localparam int SETTLE = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [6:0]  wr_data = '0;
  logic        model_lock = 1'b0;
  logic        kill = 1'b0;
  logic        pll_lock;
  logic        pll_en_o;
  logic [4:0]  pll_mult_o;
  logic [1:0]  pll_div_o;
  logic        clk_sel_o;
  logic [10:0] status_o;

  int checks = 0;
  int errors = 0;
  int settle_cnt = 0;

  always #2.5 clk = ~clk;

  assign pll_lock = model_lock && !kill;

  pll_clkctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_lock(pll_lock), .pll_en_o(pll_en_o), .pll_mult_o(pll_mult_o),
    .pll_div_o(pll_div_o), .clk_sel_o(clk_sel_o), .status_o(status_o)
  );

  // Behavioural lock model: locks SETTLE cycles after enable.
  always @(negedge clk) begin
    if (!pll_en_o) begin
      settle_cnt = 0;
      model_lock = 1'b0;
    end else if (settle_cnt < SETTLE) begin
      settle_cnt = settle_cnt + 1;
    end else begin
      model_lock = 1'b1;
    end
  end

  function automatic logic [10:0] exp_stat(logic lost, logic [4:0] m, logic [1:0] d,
                                           logic lk, logic cn, logic en);
    return {lost, m, d, lk, cn, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 0);
    chk("R1 sel", clk_sel_o, 0);
    chk("R1 mult", pll_mult_o, 0);
    chk("R1 div", pll_div_o, 0);

    // R2/R3 exhaustive sweep of multiplier and divider codes
    for (int m = 0; m < 32; m++) begin
      for (int d = 0; d < 4; d++) begin
        wr(1'b1, {d[1:0], m[4:0]});
        chk("R2 mult", pll_mult_o, m);
        chk("R2 div", pll_div_o, d);
        chk("R2 R8 status", status_o, exp_stat(0, m[4:0], d[1:0], 0, 0, 0));
        wr(1'b0, 7'h01);
        wr(1'b1, ~{d[1:0], m[4:0]});
        chk("R3 mult frozen", pll_mult_o, m);
        chk("R3 div frozen", pll_div_o, d);
        wr(1'b0, 7'h00);
        chk("R4 disabled", pll_en_o, 0);
      end
    end
    repeat (2) @(negedge clk);

    wr(1'b1, {2'd1, 5'd5});
    wr(1'b0, 7'h02);
    chk("R5 conn without enable", status_o[1:0], 2'b00);
    wr(1'b0, 7'h03);
    chk("R5 conn in enabling write", status_o[1:0], 2'b01);
    chk("R5 precondition unlocked", pll_lock, 0);
    wr(1'b0, 7'h03);
    chk("R5 conn before lock", status_o[1], 0);
    chk("R5 sel before lock", clk_sel_o, 0);
    for (int i = 0; i < 100 && !pll_lock; i++) @(negedge clk);
    @(negedge clk);
    chk("R8 lock bit", status_o, exp_stat(0, 5'd5, 2'd1, 1, 0, 1));
    wr(1'b0, 7'h03);
    chk("R5 conn accepted", status_o, exp_stat(0, 5'd5, 2'd1, 1, 1, 1));
    chk("R6 sel on", clk_sel_o, 1);

    kill = 1'b1;
    #1;
    chk("R6 sel drops at once", clk_sel_o, 0);
    @(negedge clk);
    chk("R7 lost set", status_o, exp_stat(1, 5'd5, 2'd1, 0, 0, 1));
    kill = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 stays disconnected", clk_sel_o, 0);
    chk("R7 lost sticky", status_o[10], 1);
    wr(1'b0, 7'h03);
    chk("R7 reconnect clears lost", status_o, exp_stat(0, 5'd5, 2'd1, 1, 1, 1));
    chk("R6 sel back", clk_sel_o, 1);

    wr(1'b0, 7'h01);
    chk("R9 disconnect keeps enable", status_o[1:0], 2'b01);
    chk("R9 sel off", clk_sel_o, 0);
    wr(1'b0, 7'h03);
    chk("R9 reconnect", clk_sel_o, 1);
    wr(1'b0, 7'h02);
    chk("R4 disable clears conn", status_o[1:0], 2'b00);
    chk("R4 sel off", clk_sel_o, 0);

    for (int i = 0; i < 100 && !pll_lock; i++) @(negedge clk);
    wr(1'b0, 7'h01);
    wr(1'b0, 7'h03);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run reset status", status_o, 0);
    chk("R1 mid-run reset sel", clk_sel_o, 0);
    finish_run();
  end
endmodule